// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block moves a data word left or right by a variable number of places in a single pass of combinational logic. It does not test every bit position. The amount is split into its binary weights, and each weight drives one level of two-input multiplexers. Each level either passes the word through unchanged or displaces it by 1, 2, 4, 8 or 16 places. For a 32-bit word the whole shift therefore costs five multiplexer levels, and one more level handles amounts that reach or pass the word width.

Four operations are available: logical left, logical right, arithmetic right and rotate right. The same right-moving cascade serves all four. A left shift mirrors the word on the way in and mirrors it back on the way out. The mode decides what each level feeds into the positions it vacates: zeros, the original sign bit, or the bits that fell off the low end. An amount held in a register and an amount taken from a constant field reach the same input, so both use the same datapath.

Top module: `log_shifter`

## Requirements
- R1: With mode 2'b00 (logical left), output bit i equals input bit i-amt for i >= amt, and every output bit below position amt is 0.
- R2: With mode 2'b01 (logical right), output bit i equals input bit i+amt for i+amt < W, and every output bit at or above position W-amt is 0.
- R3: With mode 2'b10 (arithmetic right), output bit i equals input bit i+amt for i+amt < W, and every vacated upper position is a copy of input bit W-1.
- R4: With mode 2'b11 (rotate right), output bit i equals input bit (i+amt) mod W, so no bit is lost and the count of ones is unchanged.
- R5: An amount of 0 returns the input word unchanged in every mode.
- R6: With an amount of W or more, the logical modes return all zeros and arithmetic right returns W copies of input bit W-1. Rotate right uses only the amount modulo W, so an amount of exactly W returns the input unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | W (32) | Word to be shifted |
| amt  | input  | $clog2(W)+1 (6) | Shift distance, 0 to 2W-1 |
| mode | input  | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| dout | output | W (32) | Shifted word, valid in the same cycle |

## Verification
The checker assumes the inputs are settled and free of X or Z whenever its conditions are evaluated. It also assumes W is a power of two, so that dropping the top amount bit gives the rotate distance modulo W. The bench changes inputs only just after a rising clock edge and compares at the falling edge. It drives only defined values, and it covers amounts on both sides of W as well as the edges 0, 1, W-1, W and 2W-1.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shf_mode_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } shf_fill_e;

  // What the vacated positions take in each mode.
  function automatic shf_fill_e fill_for(input shf_mode_e m);
    case (m)
      SH_ASR:  return FILL_SIGN;
      SH_ROR:  return FILL_WRAP;
      default: return FILL_ZERO;
    endcase
  endfunction

  // The left shift runs on the right-moving cascade between two mirrors.
  function automatic logic needs_mirror(input shf_mode_e m);
    return (m == SH_LSL);
  endfunction

endpackage

// File: rtl/shf_mirror.sv
module shf_mirror #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = en ? din[W-1-i] : din[i];
  end
endmodule

// File: rtl/shf_stage.sv
module shf_stage
  import shf_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic         en,
  input  shf_fill_e    fill,
  input  logic         sign,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i + DIST < W) begin : g_inner
      assign moved[i] = din[i+DIST];
    end else begin : g_edge
      assign moved[i] = (fill == FILL_WRAP) ? din[i+DIST-W] :
                        (fill == FILL_SIGN) ? sign : 1'b0;
    end
  end

  assign dout = en ? moved : din;
endmodule

// File: rtl/shf_clamp.sv
module shf_clamp
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         over,
  input  shf_fill_e    fill,
  input  logic         sign,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic         clamp_en;
  logic [W-1:0] flood;

  assign clamp_en = over && (fill != FILL_WRAP);
  assign flood    = {W{(fill == FILL_SIGN) && sign}};
  assign dout     = clamp_en ? flood : din;
endmodule

// File: rtl/log_shifter.sv
module log_shifter
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int LOG_W = $clog2(W),
  parameter int AMT_W = LOG_W + 1
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  input  logic [1:0]       mode,
  output logic [W-1:0]     dout
);
  shf_mode_e    mode_e;
  shf_fill_e    fill;
  logic         mirror_en;
  logic         sign;
  logic         over_range;
  logic [W-1:0] front;
  logic [W-1:0] back;
  logic [W-1:0] lvl [LOG_W+1];

  assign mode_e     = shf_mode_e'(mode);
  assign fill       = fill_for(mode_e);
  assign mirror_en  = needs_mirror(mode_e);
  assign sign       = din[W-1];
  assign over_range = |amt[AMT_W-1:LOG_W];

  shf_mirror #(.W(W)) u_in_mirror (
    .en(mirror_en), .din(din), .dout(front)
  );

  assign lvl[0] = front;

  for (genvar s = 0; s < LOG_W; s++) begin : g_lvl
    shf_stage #(.W(W), .DIST(1 << s)) u_stage (
      .en(amt[s]), .fill(fill), .sign(sign),
      .din(lvl[s]), .dout(lvl[s+1])
    );
  end

  shf_mirror #(.W(W)) u_out_mirror (
    .en(mirror_en), .din(lvl[LOG_W]), .dout(back)
  );

  shf_clamp #(.W(W)) u_clamp (
    .over(over_range), .fill(fill), .sign(sign),
    .din(back), .dout(dout)
  );
endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input logic [W-1:0]     din,
  input logic [AMT_W-1:0] amt,
  input logic [1:0]       mode,
  input logic [W-1:0]     dout,
  input logic             over_range
);
  logic [W-1:0] low_mask;
  logic [W-1:0] high_mask;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      low_mask[i]  = (i < int'(amt));
      high_mask[i] = (i >= W - int'(amt));
    end
  end

  always_comb begin
    if (mode == 2'b00 && !over_range)
      p_left_zero_fill_r1: assert ((dout & low_mask) == '0)
        else $error("R1 low bits not zero");
    if (mode == 2'b01 && !over_range)
      p_right_zero_fill_r2: assert ((dout & high_mask) == '0)
        else $error("R2 high bits not zero");
    if (mode == 2'b10)
      p_sign_kept_r3: assert (dout[W-1] == din[W-1])
        else $error("R3 sign bit changed");
    if (mode == 2'b11)
      p_rotate_ones_r4: assert ($countones(dout) == $countones(din))
        else $error("R4 ones count changed");
    if (amt == '0)
      p_zero_amount_r5: assert (dout == din)
        else $error("R5 zero amount altered data");
    if (over_range && (mode == 2'b00 || mode == 2'b01))
      p_over_logical_r6: assert (dout == '0)
        else $error("R6 logical over-range not zero");
    if (over_range && mode == 2'b10)
      p_over_arith_r6: assert (dout == {W{din[W-1]}})
        else $error("R6 arithmetic over-range not sign flood");
  end
endmodule

bind log_shifter log_shifter_chk #(.W(W), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/sim_log_shifter.sv
module sim_log_shifter;
  localparam int W     = 32;
  localparam int AMT_W = 6;

  logic             clk = 1'b0;
  logic [W-1:0]     din = '0;
  logic [AMT_W-1:0] amt = '0;
  logic [1:0]       mode = 2'b00;
  logic [W-1:0]     dout;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  log_shifter u0 (.din(din), .amt(amt), .mode(mode), .dout(dout));

  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                         input logic [1:0] m);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      case (m)
        2'b00: r[i] = (i - a >= 0) ? d[i-a] : 1'b0;
        2'b01: r[i] = (i + a < W) ? d[i+a] : 1'b0;
        2'b10: r[i] = (i + a < W) ? d[i+a] : d[W-1];
        default: r[i] = d[(i + a) % W];
      endcase
    end
    return r;
  endfunction

  function automatic string tag(input int a, input logic [1:0] m);
    if (a == 0) return "R5";
    if (a >= W) return "R6";
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] d, input int a, input logic [1:0] m);
    logic [W-1:0] exp;
    @(posedge clk);
    #1;
    din = d; amt = AMT_W'(a); mode = m;
    exp = model(d, a, m);
    @(negedge clk);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s din=%h amt=%0d mode=%b got=%h exp=%h",
               tag(a, m), d, a, m, dout, exp);
    end
  endtask

  initial begin
    // Reset state: zero word in, zero word out (R5 with amount 0).
    @(negedge clk);
    total++;
    if (dout !== '0) begin
      bad++;
      $display("FAIL R5 idle got=%h exp=%h", dout, 32'h0);
    end
    // R1 logical left edges
    apply(32'h1234_5678, 1, 2'b00);
    apply(32'hFFFF_FFFF, 31, 2'b00);
    apply(32'h8000_0001, 4, 2'b00);
    // R2 logical right edges
    apply(32'h8000_0000, 31, 2'b01);
    apply(32'hFFFF_FFFF, 16, 2'b01);
    // R3 arithmetic right, negative and positive
    apply(32'h8000_0000, 31, 2'b10);
    apply(32'h8765_4321, 8, 2'b10);
    apply(32'h7FFF_FFFF, 30, 2'b10);
    // R4 rotate right
    apply(32'h0000_0001, 1, 2'b11);
    apply(32'hDEAD_BEEF, 17, 2'b11);
    // R5 zero amount each mode
    for (int m = 0; m < 4; m++) apply(32'hA5C3_0F96, 0, 2'(m));
    // R6 at and beyond the width
    for (int m = 0; m < 4; m++) begin
      apply(32'h9ABC_DEF0, W, 2'(m));
      apply(32'h1357_9BDF, 2*W - 1, 2'(m));
      apply(32'hF000_000F, W + 5, 2'(m));
    end
    // sweep every amount and mode on sign-set and sign-clear words
    for (int a = 0; a < 2*W; a++)
      for (int m = 0; m < 4; m++) begin
        apply(32'hC0FF_EE11, a, 2'(m));
        apply(32'h3C5A_9617, a, 2'(m));
      end
    // pseudo-random patterns
    for (int k = 0; k < 1500; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      apply(rng, int'(rng[13:8]), rng[1:0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog cycles=%0d exp<=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule